// File: doc/BRIEF.md
# Low-Order Interleaved Memory Bank Controller

This block places a set of identical memory banks behind one request port. Each bank has an access time of several cycles, and that latency is modelled inside the design. A word address is split in two. The low bits select the bank and the high bits select the row inside that bank. Consecutive addresses therefore fall on different banks, and their accesses overlap in time.

Requests arrive on a valid/ready port, at most one per cycle. Writes return nothing. Each read returns its data together with the tag it was issued with, and reads come back in the order they were accepted.

An elaboration parameter selects one of two organizations:

- **Per-bank address mode.** Every bank latches its own row address when it starts. Reads to any mix of rows are pipelined, as long as successive reads target banks that are free.
- **Shared-row mode.** One row address is issued to all banks at once. Each bank captures its word into its own data register, and reads are served from those registers. The following row is fetched while the current row is still being read out.

Top module: `interleaved_mem_ctrl`

## Requirements
- R1: For an `ADDR_W`-bit address, bits `[BANK_BITS-1:0]` select one of `2^BANK_BITS` banks and bits `[ADDR_W-1:BANK_BITS]` select the row. A read of any address returns the value last written to that same address.
- R2: In per-bank address mode, a read accepted in cycle t raises `rsp_valid` in cycle t+`LATENCY`. In shared-row mode, an accepted read answers in the cycle after acceptance.
- R3: In per-bank address mode, when the bank count is at least `LATENCY`, a stream whose bank index rotates 0,1,2,... is accepted one request per cycle with no stall. The rows in the stream may be sequential or arbitrary.
- R4: In per-bank address mode, a request to a bank that is still busy holds `req_ready` low. A second read to the bank of a read accepted in cycle t is accepted no earlier than cycle t+`LATENCY`, which is `LATENCY`-1 stall cycles when presented at t+1.
- R5: Every accepted read produces exactly one response. Responses leave in acceptance order, each carrying its request's tag.
- R6: In shared-row mode, a read whose row is not held in the data registers stalls while all banks fetch that row. When no fetch is in flight, the read is accepted exactly `LATENCY` cycles after it is first presented.
- R7: In shared-row mode, a read of bank index `2^BANK_BITS`-`LATENCY` of the held row starts the fetch of the next row. After the first row, a sequential read stream is therefore accepted one per cycle.
- R8: In shared-row mode, writes are never stalled. A write to the held row also updates that bank's data register, so a following read returns the new value without a stall.
- R9: After reset, `rsp_valid` is low. In per-bank address mode `req_ready` is high. In shared-row mode a read sees `req_ready` low, because no row is held yet.
- R10: In shared-row mode, a write to a row whose fetch is still in flight is included in the data captured by that fetch. A read of that row waits until the fetch completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The request is accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; the low bits select the bank |
| req_wdata | input | DATA_W | Write data |
| req_tag | input | TAG_W | Tag returned with the read response |
| rsp_valid | output | 1 | A read response is present this cycle |
| rsp_tag | output | TAG_W | Tag of the answered read |
| rsp_data | output | DATA_W | Read data |

## Verification
The block is driven with several kinds of traffic, and each one isolates a different behaviour:

- **Sequential read streams.** In both modes these show whether bank overlap really delivers one word per cycle. In shared-row mode they also show the single miss penalty on the first row and that prefetch covers every row boundary after it.
- **Scattered rows with a rotating bank index.** This pattern separates true per-bank address registers from a design that only works for contiguous addresses.
- **Back-to-back reads to one bank.** This exposes the busy-bank stall and its exact length.
- **Writes interleaved with shared-row fetches.** A write to the held row, and a write to a row whose fetch is in flight, tell apart correct data-register update and forwarding from stale captured data.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

   // Bank organization selected at elaboration
   typedef enum logic [0:0] {
      ORG_SYNC  = 1'b0,   // one row address shared by all banks, per-bank data registers
      ORG_INDEP = 1'b1    // each bank latches its own row address
   } ilv_org_e;

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
   parameter int ROW_W    = 6,
   parameter int DATA_W   = 16,
   parameter int LATENCY  = 4,
   parameter bit OWN_AREG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_start,
   input  logic [ROW_W-1:0]  acc_row,
   input  logic              wr_en,
   input  logic [ROW_W-1:0]  wr_row,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              reg_wr,
   output logic              busy,
   output logic              fin,
   output logic [DATA_W-1:0] rdata
);

   localparam int ROWS  = 1 << ROW_W;
   localparam int CNT_W = $clog2(LATENCY + 1);

   logic [DATA_W-1:0] mem [ROWS];
   logic [ROW_W-1:0]  crow;
   logic [DATA_W-1:0] fwd;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_row] <= wr_data;
   end

   generate
      if (LATENCY == 1) begin : g_lat1
         assign busy = 1'b0;
         assign fin  = acc_start;
         assign crow = acc_row;
      end else begin : g_latn
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (acc_start)  cnt <= CNT_W'(LATENCY - 1);
            else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
         end

         assign busy = (cnt != '0);
         assign fin  = (cnt == CNT_W'(1));

         if (OWN_AREG) begin : g_areg
            logic [ROW_W-1:0] areg;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)         areg <= '0;
               else if (acc_start) areg <= acc_row;
            end
            assign crow = areg;
         end else begin : g_shared
            assign crow = acc_row;
            AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n) busy |-> $stable(acc_row)); // R6
         end
      end
   endgenerate

   // a write landing on the completing row in the same cycle is forwarded
   assign fwd = (wr_en && (wr_row == crow)) ? wr_data : mem[crow];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '0;
      else if (fin)    rdata <= fwd;
      else if (reg_wr) rdata <= wr_data;
   end

   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n) acc_start |-> !busy); // R4

endmodule

// File: rtl/interleaved_mem_ctrl.sv
module interleaved_mem_ctrl #(
   parameter int               ADDR_W    = 8,
   parameter int               BANK_BITS = 2,
   parameter int               DATA_W    = 16,
   parameter int               TAG_W     = 4,
   parameter int               LATENCY   = 4,
   parameter ilv_pkg::ilv_org_e ORG      = ilv_pkg::ORG_INDEP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              rsp_valid,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic [DATA_W-1:0] rsp_data
);

   localparam int NB     = 1 << BANK_BITS;
   localparam int ROW_W  = ADDR_W - BANK_BITS;
   localparam bit PF_EN  = (LATENCY <= NB);
   localparam int PF_IDX = PF_EN ? (NB - LATENCY) : 0;

   initial begin
      if (BANK_BITS < 1 || BANK_BITS >= ADDR_W) $fatal(1, "BANK_BITS must leave at least one row bit");
      if (LATENCY < 1)                          $fatal(1, "LATENCY must be at least one cycle");
      if (TAG_W < 1 || DATA_W < 1)              $fatal(1, "TAG_W and DATA_W must be positive");
   end

   logic [BANK_BITS-1:0] req_bank;
   logic [ROW_W-1:0]     req_row;
   assign req_bank = req_addr[BANK_BITS-1:0];       // R1
   assign req_row  = req_addr[ADDR_W-1:BANK_BITS];

   logic [NB-1:0]     b_start, b_wen, b_regwr, b_busy, b_fin;
   logic [ROW_W-1:0]  b_row   [NB];
   logic [DATA_W-1:0] b_rdata [NB];

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bank
         ilv_bank #(
            .ROW_W    (ROW_W),
            .DATA_W   (DATA_W),
            .LATENCY  (LATENCY),
            .OWN_AREG (ORG == ilv_pkg::ORG_INDEP)
         ) i_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_start (b_start[b]),
            .acc_row   (b_row[b]),
            .wr_en     (b_wen[b]),
            .wr_row    (req_row),
            .wr_data   (req_wdata),
            .reg_wr    (b_regwr[b]),
            .busy      (b_busy[b]),
            .fin       (b_fin[b]),
            .rdata     (b_rdata[b])
         );
      end

      if (ORG == ilv_pkg::ORG_INDEP) begin : g_indep
         logic acc;
         logic                 dl_vld  [LATENCY];
         logic [BANK_BITS-1:0] dl_bank [LATENCY];
         logic [TAG_W-1:0]     dl_tag  [LATENCY];

         assign req_ready = !b_busy[req_bank];
         assign acc       = req_valid && req_ready;

         for (genvar b = 0; b < NB; b++) begin : g_sel
            assign b_start[b] = acc && !req_write && (req_bank == BANK_BITS'(b));
            assign b_wen[b]   = acc &&  req_write && (req_bank == BANK_BITS'(b));
            assign b_row[b]   = req_row;
            assign b_regwr[b] = 1'b0;
         end

         // response slot travels alongside the bank access, so order is kept
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < LATENCY; i++) begin
                  dl_vld[i]  <= 1'b0;
                  dl_bank[i] <= '0;
                  dl_tag[i]  <= '0;
               end
            end else begin
               dl_vld[0]  <= acc && !req_write;
               dl_bank[0] <= req_bank;
               dl_tag[0]  <= req_tag;
               for (int i = 1; i < LATENCY; i++) begin
                  dl_vld[i]  <= dl_vld[i-1];
                  dl_bank[i] <= dl_bank[i-1];
                  dl_tag[i]  <= dl_tag[i-1];
               end
            end
         end

         assign rsp_valid = dl_vld[LATENCY-1];
         assign rsp_tag   = dl_tag[LATENCY-1];
         assign rsp_data  = b_rdata[dl_bank[LATENCY-1]];

         AST_ONE_COMPLETION: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(b_fin)); // R5
         AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && b_busy[req_bank]) |-> !req_ready); // R4
      end else begin : g_sync
         logic             lat_vld;
         logic [ROW_W-1:0] lat_row, fetch_row_q, go_row, cur_row;
         logic             fetching, fin_all, hit, rd_acc, miss_start, pf_start, go;
         logic             rsp_vld_q;
         logic [TAG_W-1:0] rsp_tag_q;
         logic [DATA_W-1:0] rsp_data_q;

         assign fetching   = |b_busy;
         assign fin_all    = &b_fin;
         assign hit        = lat_vld && (req_row == lat_row);
         assign req_ready  = req_write || hit;
         assign rd_acc     = req_valid && !req_write && hit;
         assign miss_start = req_valid && !req_write && !hit && !fetching;

         if (PF_EN) begin : g_pf
            assign pf_start = rd_acc && !fetching && (req_bank == BANK_BITS'(PF_IDX));
         end else begin : g_nopf
            assign pf_start = 1'b0;
         end

         assign go      = miss_start || pf_start;
         assign go_row  = pf_start ? (req_row + ROW_W'(1)) : req_row;
         assign cur_row = go ? go_row : fetch_row_q;

         for (genvar b = 0; b < NB; b++) begin : g_sel
            assign b_start[b] = go;
            assign b_row[b]   = cur_row;
            assign b_wen[b]   = req_valid && req_write && (req_bank == BANK_BITS'(b));
            assign b_regwr[b] = b_wen[b] && hit;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fetch_row_q <= '0;
               lat_vld     <= 1'b0;
               lat_row     <= '0;
            end else begin
               if (go) fetch_row_q <= go_row;
               if (fin_all) begin
                  lat_vld <= 1'b1;
                  lat_row <= cur_row;
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rsp_vld_q  <= 1'b0;
               rsp_tag_q  <= '0;
               rsp_data_q <= '0;
            end else begin
               rsp_vld_q  <= rd_acc;
               rsp_tag_q  <= req_tag;
               rsp_data_q <= b_rdata[req_bank];
            end
         end

         assign rsp_valid = rsp_vld_q;
         assign rsp_tag   = rsp_tag_q;
         assign rsp_data  = rsp_data_q;

         AST_RESP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $past(req_valid && req_ready && !req_write)); // R2
         AST_LATCH_ON_FIN: assert property (@(posedge clk) disable iff (!rst_n) fin_all |=> lat_vld); // R6
      end
   endgenerate

endmodule

// File: tb/test_interleaved_mem_ctrl.sv
`timescale 1ns/1ps
module test_interleaved_mem_ctrl;

   localparam int LAT = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic        rv [2];
   logic        rw [2];
   logic [7:0]  ra [2];
   logic [15:0] rdat [2];
   logic [3:0]  rt [2];
   logic        rr [2];
   logic        sv [2];
   logic [3:0]  st [2];
   logic [15:0] sd [2];

   interleaved_mem_ctrl #(.LATENCY(LAT), .ORG(ilv_pkg::ORG_INDEP)) i_interleaved_mem_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_ready(rr[0]), .req_write(rw[0]),
      .req_addr(ra[0]), .req_wdata(rdat[0]), .req_tag(rt[0]),
      .rsp_valid(sv[0]), .rsp_tag(st[0]), .rsp_data(sd[0]));

   interleaved_mem_ctrl #(.LATENCY(LAT), .ORG(ilv_pkg::ORG_SYNC)) i_interleaved_mem_ctrl_sync (
      .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_ready(rr[1]), .req_write(rw[1]),
      .req_addr(ra[1]), .req_wdata(rdat[1]), .req_tag(rt[1]),
      .rsp_valid(sv[1]), .rsp_tag(st[1]), .rsp_data(sd[1]));

   int n_checks = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;

   logic [15:0] ref_mem [2][256];
   logic [15:0] exp_d [2][64];
   logic [3:0]  exp_t [2][64];
   int          exp_c [2][64];
   int          wp [2];
   int          rp [2];
   logic [15:0] last_d [2];
   int          k;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // response monitor: order, tag, data and arrival cycle
   always @(negedge clk) begin
      for (int u = 0; u < 2; u++) begin
         if (rst_n && sv[u]) begin
            if (wp[u] == rp[u]) begin
               check(1'b0, "R5", $sformatf("unit%0d unexpected response", u), 1, 0);
            end else begin
               k = rp[u] % 64;
               check(st[u] == exp_t[u][k], "R5", $sformatf("unit%0d tag", u), int'(st[u]), int'(exp_t[u][k]));
               check(sd[u] == exp_d[u][k], "R1", $sformatf("unit%0d data", u), int'(sd[u]), int'(exp_d[u][k]));
               check(cyc == exp_c[u][k], "R2", $sformatf("unit%0d response cycle", u), cyc, exp_c[u][k]);
               last_d[u] = sd[u];
               rp[u]++;
            end
         end
      end
   end

   task automatic send(input int u, input bit wr, input int addr, input logic [15:0] d,
                       input logic [3:0] tag, output int stalls);
      @(negedge clk);
      rv[u] = 1'b1; rw[u] = wr; ra[u] = 8'(addr); rdat[u] = d; rt[u] = tag;
      stalls = 0;
      #1;
      while (!rr[u]) begin
         @(negedge clk);
         #1;
         stalls++;
      end
      if (wr) begin
         ref_mem[u][addr] = d;
      end else begin
         exp_d[u][wp[u] % 64] = ref_mem[u][addr];
         exp_t[u][wp[u] % 64] = tag;
         exp_c[u][wp[u] % 64] = cyc + ((u == 0) ? LAT : 1);
         wp[u]++;
      end
      @(posedge clk);
      #1;
      rv[u] = 1'b0;
   endtask

   task automatic drain(input int u);
      repeat (LAT + 3) @(negedge clk);
      check(wp[u] == rp[u], "R5", $sformatf("unit%0d all reads answered", u), rp[u], wp[u]);
   endtask

   task automatic t_reset();
      @(negedge clk);
      #1;
      check(sv[0] == 1'b0 && sv[1] == 1'b0, "R9", "rsp_valid after reset", int'(sv[0]) + int'(sv[1]), 0);
      check(rr[0] == 1'b1, "R9", "per-bank mode ready after reset", int'(rr[0]), 1);
      check(rr[1] == 1'b0, "R9", "shared-row read ready after reset", int'(rr[1]), 0);
   endtask

   task automatic t_fill(input int u);
      int s, tot;
      tot = 0;
      for (int a = 0; a < 256; a++) begin
         send(u, 1'b1, a, 16'(a * 13 + u * 4096 + 5), 4'(a), s);
         tot += s;
      end
      check(tot == 0, (u == 1) ? "R8" : "R3", $sformatf("unit%0d write stalls", u), tot, 0);
   endtask

   task automatic t_seq(input int u);
      int s, first, rest;
      rest = 0;
      first = 0;
      for (int a = 0; a < 64; a++) begin
         send(u, 1'b0, a, 16'h0, 4'(a), s);
         if (a == 0) first = s; else rest += s;
      end
      if (u == 0) begin
         check(first + rest == 0, "R3", "sequential stream stalls", first + rest, 0);
      end else begin
         check(first == LAT, "R6", "first-row miss stall", first, LAT);
         check(rest == 0, "R7", "sequential stream stalls after first row", rest, 0);
      end
      drain(u);
   endtask

   task automatic t_same_bank();
      int s0, s1;
      send(0, 1'b0, 4, 16'h0, 4'h1, s0);
      send(0, 1'b0, 8, 16'h0, 4'h2, s1);
      check(s0 == 0, "R4", "first read to idle bank", s0, 0);
      check(s1 == LAT - 1, "R4", "stall on busy bank", s1, LAT - 1);
      drain(0);
   endtask

   task automatic t_scatter();
      int s, tot;
      tot = 0;
      for (int i = 0; i < 32; i++) begin
         send(0, 1'b0, (((i * 23) & 63) << 2) | (i % 4), 16'h0, 4'(15 - (i % 16)), s);
         tot += s;
      end
      check(tot == 0, "R3", "scattered rows with rotating bank", tot, 0);
      drain(0);
   endtask

   task automatic t_sync_latched();
      int s0, s1, s2;
      send(1, 1'b0, 201, 16'h0, 4'h3, s0);
      send(1, 1'b1, 202, 16'hBEEF, 4'h0, s1);
      send(1, 1'b0, 202, 16'h0, 4'h4, s2);
      check(s0 == LAT, "R6", "miss on new row", s0, LAT);
      check(s1 == 0, "R8", "write to held row stall", s1, 0);
      check(s2 == 0, "R8", "read after write to held row stall", s2, 0);
      drain(1);
      check(last_d[1] == 16'hBEEF, "R8", "data register updated by write", int'(last_d[1]), 16'hBEEF);
   endtask

   task automatic t_sync_inflight();
      int s0, s1, s2;
      send(1, 1'b0, 248, 16'h0, 4'h5, s0);        // row 62, bank 0: starts fetch of row 63
      send(1, 1'b1, 253, 16'hC0DE, 4'h0, s1);     // row 63 while its fetch is in flight
      send(1, 1'b0, 253, 16'h0, 4'h6, s2);
      check(s1 == 0, "R8", "write during fetch stall", s1, 0);
      check(s2 == 2, "R10", "read waits for in-flight fetch", s2, 2);
      drain(1);
      check(last_d[1] == 16'hC0DE, "R10", "fetch captures in-flight write", int'(last_d[1]), 16'hC0DE);
   endtask

   initial begin
      for (int u = 0; u < 2; u++) begin
         rv[u] = 1'b0; rw[u] = 1'b0; ra[u] = '0; rdat[u] = '0; rt[u] = '0;
         wp[u] = 0; rp[u] = 0; last_d[u] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill(0);
      t_fill(1);
      t_seq(0);
      t_seq(1);
      t_same_bank();
      t_scatter();
      t_sync_latched();
      t_sync_inflight();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule